// File: doc/BRIEF.md
# Tiled Depth Surface Copy Engine

This block copies a rectangle of depth pixels between a tiled depth surface and a packed linear staging buffer. The transfer runs in either direction. A readout moves data from the tiled surface to the staging buffer. A write-back moves staging data into the tiled surface. The engine walks the rectangle row by row. For each pixel it works out the swizzled tiled word address, reads the source word and writes the same word to the destination on the following cycle.

Two tile layouts are supported, one for 16-bit depth and one for 32-bit depth. Each layout interleaves X and Y bits and XORs some of them. A surface that belongs to the window system stores its rows bottom-up, so the engine can mirror Y on the tiled side. Software captures all transfer settings with a start pulse. It then waits for the done pulse.

Top module: `dtile_copy`

## Requirements
- R1: In 16-bit mode the tiled byte address is built as follows:
  - bit 0 is 0, bits 3:1 are x[2:0], bits 6:4 are y[2:0] and bit 7 is x[3];
  - bits 9:8 are blk[1:0], bit 10 is y[3] and bit 11 is x[4]^y[4];
  - the bits from bit 12 up are blk>>2.
  - The word address driven on the port is the byte address divided by 2.
- R2: In 32-bit mode the tiled byte address is built as follows:
  - bits 1:0 are 0, bits 4:2 are x[2:0], bits 6:5 are y[1:0] and bit 7 is x[4]^y[2];
  - bits 9:8 are blk[1:0], bit 10 is y[3] and bit 11 is x[3]^y[4];
  - the bits from bit 12 up are blk>>2.
  - The word address driven on the port is the byte address divided by 4.
- R3: The tile block index blk is (y>>4)·B + (x>>5) in 16-bit mode and (y>>4)·B + (x>>4) in 32-bit mode. B is the surface pitch in bytes rounded up to a multiple of 64, then divided by 64.
- R4: With flip on, the tiled-side row is (surf_h−1)−(org_y+row). With flip off, it is org_y+row. The tiled-side column is always org_x+col.
- R5: Pixels are visited in row-major order. The staging-side word address of pixel (row, col) is row·width+col, so the staging pitch is width times the pixel size.
- R6: Each pixel takes two cycles. The first cycle is a read of the source surface. The second cycle is a write of the returned read data to the destination surface. The source is the tiled surface in readout and the staging buffer in write-back. mem_lin_o is 1 for an access to the staging buffer and 0 for the tiled surface.
- R7: A write-back started with wr_allow_i low makes no memory access. done_o follows in the next cycle.
- R8: A rectangle with zero width or zero height makes no memory access. done_o follows in the next cycle.
- R9: busy_o is high from the cycle after an accepted start through the done cycle. A start pulse that arrives while busy_o is high is ignored.
- R10: done_o is a single-cycle pulse. A rectangle of N pixels finishes with done_o high 2N+1 cycles after start is sampled.
- R11: After reset, busy_o, done_o and mem_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; latches all settings |
| to_tiled_i | input | 1 | 1 = write-back (staging to tiled), 0 = readout |
| wr_allow_i | input | 1 | Write flag; write-back copies only when set |
| flip_i | input | 1 | Mirror Y on the tiled side |
| fmt32_i | input | 1 | 1 = 32-bit depth, 0 = 16-bit depth |
| org_x_i | input | COORD_W | Rectangle origin X |
| org_y_i | input | COORD_W | Rectangle origin Y |
| width_i | input | COORD_W | Rectangle width in pixels |
| height_i | input | COORD_W | Rectangle height in pixels |
| pitch_i | input | PITCH_W | Surface pitch in bytes |
| surf_h_i | input | COORD_W | Surface height in rows |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_lin_o | output | 1 | 1 = staging buffer, 0 = tiled surface |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid the cycle after a read |

## Verification
The assertions watch, on every cycle, the access pairing: each read is followed by a write to the other surface, and no write occurs without a read just before it. They also check that accesses happen only while busy, that done lasts one cycle, and that skipped or empty transfers complete at once with no access. Only the bench scenarios can show that the swizzle layouts, the block index, the Y mirror and the row-major staging offsets are right. The bench shows this by comparing the destination contents with source patterns at independently computed addresses. The same applies to the exact cycle count of each transfer.

// File: rtl/dtile_pkg.sv
package dtile_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } dt_state_e;
endpackage

// File: rtl/dtile_swizzle.sv
module dtile_swizzle #(
  parameter int COORD_W = 12,
  parameter int BLK_W   = 11,
  parameter int ADDR_W  = 24
) (
  input  logic               fmt32_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [BLK_W-1:0]   blk_row_i,
  output logic [ADDR_W-1:0]  word_o
);
  localparam int BA_W   = COORD_W + BLK_W;
  localparam int BYTE_W = BA_W + 10;

  logic [BA_W-1:0]   ba;
  logic [BA_W-1:0]   xblk;
  logic [BYTE_W-1:0] byte_a;

  always_comb begin
    xblk = fmt32_i ? BA_W'(x_i[COORD_W-1:4]) : BA_W'(x_i[COORD_W-1:5]);
    ba   = BA_W'(y_i[COORD_W-1:4]) * BA_W'(blk_row_i) + xblk;
    if (fmt32_i) begin
      byte_a = {ba[BA_W-1:2], x_i[3] ^ y_i[4], y_i[3], ba[1:0],
                x_i[4] ^ y_i[2], y_i[1:0], x_i[2:0], 2'b00};
      word_o = ADDR_W'(byte_a >> 2);
    end else begin
      byte_a = {ba[BA_W-1:2], x_i[4] ^ y_i[4], y_i[3], ba[1:0],
                x_i[3], y_i[2:0], x_i[2:0], 1'b0};
      word_o = ADDR_W'(byte_a >> 1);
    end
  end
endmodule

// File: rtl/dtile_walker.sv
module dtile_walker #(
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               step_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] height_i,
  output logic [COORD_W-1:0] col_o,
  output logic [COORD_W-1:0] row_o,
  output logic [ADDR_W-1:0]  lin_o,
  output logic               last_o
);
  logic [COORD_W-1:0] col_q, col_d, row_q, row_d;
  logic [ADDR_W-1:0]  lin_q, lin_d;
  logic               row_end;
  logic               upd;

  assign row_end = (col_q == width_i - COORD_W'(1));
  assign last_o  = row_end && (row_q == height_i - COORD_W'(1));
  assign upd     = clear_i | step_i;

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    lin_d = lin_q;
    if (clear_i) begin
      col_d = '0;
      row_d = '0;
      lin_d = '0;
    end else if (step_i) begin
      lin_d = lin_q + ADDR_W'(1);
      if (row_end) begin
        col_d = '0;
        row_d = row_q + COORD_W'(1);
      end else begin
        col_d = col_q + COORD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      lin_q <= '0;
    end else if (upd) begin
      col_q <= col_d;
      row_q <= row_d;
      lin_q <= lin_d;
    end
  end

  assign col_o = col_q;
  assign row_o = row_q;
  assign lin_o = lin_q;
endmodule

// File: rtl/dtile_ctrl.sv
module dtile_ctrl
  import dtile_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      empty_i,
  input  logic      skip_i,
  input  logic      last_i,
  output logic      load_o,
  output logic      step_o,
  output dt_state_e state_o
);
  dt_state_e st_q, st_d;

  assign load_o = start_i && (st_q == ST_IDLE);
  assign step_o = (st_q == ST_WR) && !last_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (load_o) st_d = (empty_i || skip_i) ? ST_FIN : ST_RD;
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = last_i ? ST_FIN : ST_RD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/dtile_copy.sv
module dtile_copy
  import dtile_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int PITCH_W = 16,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               to_tiled_i,
  input  logic               wr_allow_i,
  input  logic               flip_i,
  input  logic               fmt32_i,
  input  logic [COORD_W-1:0] org_x_i,
  input  logic [COORD_W-1:0] org_y_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] height_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [COORD_W-1:0] surf_h_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic               mem_lin_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  localparam int BLK_W = PITCH_W - 5;

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // captured transfer settings
  logic               dir_q, flip_q, fmt_q;
  logic [COORD_W-1:0] ox_q, oy_q, w_q, h_q, sh_q;
  logic [BLK_W-1:0]   blk_q;
  logic [PITCH_W:0]   pitch_up;

  logic      load, step, last, empty, skip;
  dt_state_e state;

  assign pitch_up = {1'b0, pitch_i} + (PITCH_W+1)'(63);
  assign empty    = (width_i == '0) || (height_i == '0);
  assign skip     = to_tiled_i && !wr_allow_i;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q  <= 1'b0;
      flip_q <= 1'b0;
      fmt_q  <= 1'b0;
      ox_q   <= '0;
      oy_q   <= '0;
      w_q    <= '0;
      h_q    <= '0;
      sh_q   <= '0;
      blk_q  <= '0;
    end else if (load) begin
      dir_q  <= to_tiled_i;
      flip_q <= flip_i;
      fmt_q  <= fmt32_i;
      ox_q   <= org_x_i;
      oy_q   <= org_y_i;
      w_q    <= width_i;
      h_q    <= height_i;
      sh_q   <= surf_h_i;
      blk_q  <= pitch_up[PITCH_W:6];
    end
  end

  dtile_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .empty_i (empty),
    .skip_i  (skip),
    .last_i  (last),
    .load_o  (load),
    .step_o  (step),
    .state_o (state)
  );

  logic [COORD_W-1:0] col, row, tx, ty_raw, ty;
  logic [ADDR_W-1:0]  lin_addr, tile_addr;

  dtile_walker #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clear_i  (load),
    .step_i   (step),
    .width_i  (w_q),
    .height_i (h_q),
    .col_o    (col),
    .row_o    (row),
    .lin_o    (lin_addr),
    .last_o   (last)
  );

  assign tx     = ox_q + col;
  assign ty_raw = oy_q + row;
  assign ty     = flip_q ? (sh_q - COORD_W'(1) - ty_raw) : ty_raw;

  dtile_swizzle #(.COORD_W(COORD_W), .BLK_W(BLK_W), .ADDR_W(ADDR_W)) u_swz (
    .fmt32_i   (fmt_q),
    .x_i       (tx),
    .y_i       (ty),
    .blk_row_i (blk_q),
    .word_o    (tile_addr)
  );

  // read side is the source, write side the destination
  always_comb begin
    mem_req_o   = (state == ST_RD) || (state == ST_WR);
    mem_we_o    = (state == ST_WR);
    mem_lin_o   = mem_we_o ? !dir_q : dir_q;
    mem_addr_o  = mem_lin_o ? lin_addr : tile_addr;
    mem_wdata_o = mem_rdata_i;
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_FIN);
endmodule

// File: rtl/dtile_copy_chk.sv
module dtile_copy_chk #(
  parameter int COORD_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               to_tiled_i,
  input logic               wr_allow_i,
  input logic [COORD_W-1:0] width_i,
  input logic [COORD_W-1:0] height_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic               mem_lin_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R9

  AST_ACCESS_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (busy_o && !done_o)); // R6

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o && (mem_lin_o != $past(mem_lin_o)))); // R6

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o)); // R6

  AST_SKIP_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && to_tiled_i && !wr_allow_i) |=> (done_o && !mem_req_o)); // R7

  AST_EMPTY_RECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && ((width_i == '0) || (height_i == '0))) |=> (done_o && !mem_req_o)); // R8

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R9
endmodule

bind dtile_copy dtile_copy_chk #(.COORD_W(COORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .to_tiled_i (to_tiled_i),
  .wr_allow_i (wr_allow_i),
  .width_i    (width_i),
  .height_i   (height_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_lin_o  (mem_lin_o)
);

// File: tb/dtile_copy_bench.sv
`timescale 1ns/1ps
module dtile_copy_bench;
  localparam int COORD_W = 12;
  localparam int PITCH_W = 16;
  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 32;
  localparam int NV = 7;
  // fmt32, flip, to_tiled, wr_allow, ox, oy, w, h, pitch, surf_h
  localparam int VEC [NV][10] = '{
    '{0, 0, 0, 0,  3,  2,  9,  4, 128, 32},
    '{1, 0, 0, 0, 10, 13,  8,  6, 192, 40},
    '{0, 1, 0, 0, 28,  5,  7, 14, 256, 48},
    '{1, 1, 0, 0, 14, 20,  6,  8, 128, 40},
    '{0, 0, 1, 1, 30, 12,  5,  7, 160, 32},
    '{1, 1, 1, 1,  2,  9, 10,  3, 256, 36},
    '{1, 0, 1, 1, 15, 15,  4,  4,  64, 24}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, to_tiled = 1'b0, wr_allow = 1'b0, flip = 1'b0, fmt32 = 1'b0;
  logic [COORD_W-1:0] ox = '0, oy = '0, w = '0, h = '0, sh = '0;
  logic [PITCH_W-1:0] pitch = '0;
  logic busy, done, mem_req, mem_we, mem_lin;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int acc_cnt = 0;
  int cur_gen = 0;
  logic [31:0] tmem [int unsigned];
  logic [31:0] lmem [int unsigned];
  int tgen [int unsigned];
  int lgen [int unsigned];

  always #5 clk = ~clk;

  dtile_copy #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dtile_copy (
    .clk(clk), .rst_n(rst_n), .start_i(start), .to_tiled_i(to_tiled),
    .wr_allow_i(wr_allow), .flip_i(flip), .fmt32_i(fmt32),
    .org_x_i(ox), .org_y_i(oy), .width_i(w), .height_i(h),
    .pitch_i(pitch), .surf_h_i(sh), .busy_o(busy), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_lin_o(mem_lin),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] peek(input logic lin, input int unsigned a);
    if (lin) begin
      if (lmem.exists(a) && lgen[a] == cur_gen) return lmem[a];
      return 32'h3000_0000 ^ a;
    end
    if (tmem.exists(a) && tgen[a] == cur_gen) return tmem[a];
    return 32'h7000_0000 ^ a;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        if (mem_lin) begin lmem[mem_addr] = mem_wdata; lgen[mem_addr] = cur_gen; end
        else begin tmem[mem_addr] = mem_wdata; tgen[mem_addr] = cur_gen; end
      end else begin
        mem_rdata <= peek(mem_lin, mem_addr);
      end
    end
  end

  // expected tiled word address from R1, R2, R3
  function automatic int unsigned ref_tile(input int f32, input int x, input int y, input int p);
    int unsigned b, a;
    int bpr;
    bpr = (p + 63) / 64;
    if (f32 != 0) begin
      b = (y / 16) * bpr + x / 16;
      a = ((x & 7) << 2) | ((y & 3) << 5) | ((((x >> 4) ^ (y >> 2)) & 1) << 7)
        | ((b & 3) << 8) | (((y >> 3) & 1) << 10) | ((((x >> 3) ^ (y >> 4)) & 1) << 11)
        | ((b >> 2) << 12);
      return a / 4;
    end
    b = (y / 16) * bpr + x / 32;
    a = ((x & 7) << 1) | ((y & 7) << 4) | (((x >> 3) & 1) << 7)
      | ((b & 3) << 8) | (((y >> 3) & 1) << 10) | ((((x >> 4) ^ (y >> 4)) & 1) << 11)
      | ((b >> 2) << 12);
    return a / 2;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_in(input int v[10]);
    fmt32 = v[0][0]; flip = v[1][0]; to_tiled = v[2][0]; wr_allow = v[3][0];
    ox = COORD_W'(v[4]); oy = COORD_W'(v[5]); w = COORD_W'(v[6]); h = COORD_W'(v[7]);
    pitch = PITCH_W'(v[8]); sh = COORD_W'(v[9]);
  endtask

  // pulse start, count negedges until done; optional second start at cycle inj
  task automatic launch(input int inj, output int cyc, output int acc);
    int a0;
    cur_gen++;
    a0 = acc_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      if (cyc == inj) begin
        check("R9", "busy during run", busy, 1);
        ox = ox + 1; w = 2; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (!done) check("R10", "done timeout", 0, 1);
    @(negedge clk);
    check("R10", "done one cycle", done, 0);
    check("R9", "idle after done", busy, 0);
    acc = acc_cnt - a0;
  endtask

  task automatic data_check(input int v[10]);
    int bad;
    bad = 0;
    for (int r = 0; r < v[7]; r++) begin
      for (int c = 0; c < v[6]; c++) begin
        int ty;
        int unsigned ta, la;
        ty = (v[1] != 0) ? (v[9] - 1 - (v[5] + r)) : (v[5] + r);
        ta = ref_tile(v[0], v[4] + c, ty, v[8]);
        la = r * v[6] + c;
        if (v[2] == 0) begin
          if (peek(1'b1, la) != (32'h7000_0000 ^ ta)) bad++;
        end else begin
          if (peek(1'b0, ta) != (32'h3000_0000 ^ la)) bad++;
        end
      end
    end
    check(v[0] != 0 ? "R2 R3 R4 R5" : "R1 R3 R4 R5", "pixel mismatches", bad, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, acc, n;
    repeat (3) @(negedge clk);
    check("R11", "busy after reset", busy, 0);
    check("R11", "done after reset", done, 0);
    check("R11", "req after reset", mem_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "idle after release", {busy, done, mem_req}, 0);

    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i]);
      launch(-1, cyc, acc);
      n = VEC[i][6] * VEC[i][7];
      check("R10", "transfer cycles", cyc, 2 * n + 1);
      check("R6", "access count", acc, 2 * n);
      data_check(VEC[i]);
    end

    // start while busy is ignored
    set_in(VEC[1]);
    launch(5, cyc, acc);
    check("R9", "cycles with late start", cyc, 2 * 48 + 1);
    check("R9", "accesses with late start", acc, 96);
    data_check(VEC[1]);

    // write-back without write flag
    set_in(VEC[4]);
    wr_allow = 1'b0;
    launch(-1, cyc, acc);
    check("R7", "skip cycles", cyc, 1);
    check("R7", "skip accesses", acc, 0);

    // zero width, then zero height
    set_in(VEC[0]);
    w = '0;
    launch(-1, cyc, acc);
    check("R8", "zero width cycles", cyc, 1);
    check("R8", "zero width accesses", acc, 0);
    set_in(VEC[2]);
    h = '0;
    launch(-1, cyc, acc);
    check("R8", "zero height cycles", cyc, 1);
    check("R8", "zero height accesses", acc, 0);

    // single pixel
    set_in(VEC[3]);
    w = 1; h = 1;
    launch(-1, cyc, acc);
    check("R10", "one pixel cycles", cyc, 3);
    check("R6", "one pixel value", peek(1'b1, 0),
          32'h7000_0000 ^ ref_tile(1, 14, 40 - 1 - 20, 128));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule